// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide command and status port of one eight-input interrupt controller. A host writes initialization words and operation commands through a one-bit address, a write strobe and 8-bit data. It reads back the mask register, the request register, the in-service register, or a poll result through the same port. The block sequences the initialization words and rejects unsupported modes. It holds the mask, the vector base, the end-of-interrupt and nesting mode flags, special mask mode and the readback selection.

The request and in-service registers live in neighbouring logic, and the block only reads them. The neighbour also supplies the winning pending request. Second-type operation commands are decoded onto a strobe with separate fields, so that the neighbour can apply end-of-interrupt and rotation. A start of initialization is signalled on `init_o`, so that the neighbour clears its request register and returns its priority pointer to 7. `ready_o` tells request capture whether to accept inputs. A read in poll mode returns the winner and pulses `ack_o`, so that the neighbour acknowledges that pin exactly as a vector fetch would.

Top module: `pic_prog_if`

## Requirements
- R1: After reset, `ready_o`, `mask_o`, `vec_base_o`, `aeoi_o`, `sfn_o` and `smm_o` are all 0, and a read at address 0 returns `irr_i`.
- R2: A write at address 0 with data bit 4 set starts initialization. In that write cycle `init_o` is 1. From the next cycle, `ready_o` is 0, the mask is 0, special mask mode is off, poll is off, and address-0 reads return `irr_i`.
- R3: If that first word has bit 1 set (single mode) or bit 0 clear (no fourth word), the sequence aborts. `ready_o` stays 0, and later address-1 writes load the mask while `vec_base_o` is unchanged.
- R4: After an accepted first word, the next address-1 write sets `vec_base_o` to data AND 0xF8. The address-1 write after that is taken as the third word and changes neither the base nor the mask.
- R5: The following address-1 write is the fourth word. With bit 0 set, it raises `ready_o`, sets `aeoi_o` to bit 1, and sets `sfn_o` to bit 4 only when `IS_MASTER` is 1. With bit 0 clear, `ready_o` stays 0 and the next address-1 write is taken again as the fourth word.
- R6: When no initialization word is pending, an address-1 write loads `mask_o`, and an address-1 read without poll returns it.
- R7: While ready, an address-0 write with bits 4 and 3 clear pulses `ocw2_stb_o` in that cycle. The fields are rotate = bit 7, specific = bit 6, end-of-interrupt = bit 5, and level = bits 2:0. While not ready, address-0 writes without bit 4 are ignored: no strobe, and no change to the readback selection.
- R8: While ready, an address-0 write with bit 3 set (bit 4 clear) updates `smm_o` to bit 5 only if bit 6 is set.
- R9: In that same write, bit 1 set selects readback: bit 0 = 1 selects in-service and 0 selects request. It also sets poll to bit 2. With bit 1 clear, the selection and poll are unchanged.
- R10: A read with poll pending clears poll. If `win_valid_i` is 1, it returns 0x80 OR the winning pin and pulses `ack_o` with `ack_pin_o` equal to the pin. Otherwise it returns 0 and `ack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (poll side effect) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| irr_i | input | 8 | Request register from capture logic |
| isr_i | input | 8 | In-service register |
| win_valid_i | input | 1 | Resolver has an eligible request |
| win_pin_i | input | 3 | Winning pin |
| ack_o | output | 1 | Poll read acknowledges the winner |
| ack_pin_o | output | 3 | Pin acknowledged |
| ready_o | output | 1 | Initialization complete; gates request capture |
| init_o | output | 1 | Initialization start: clear requests, priority pointer to 7 |
| mask_o | output | 8 | Mask register |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| aeoi_o | output | 1 | Automatic end-of-interrupt mode |
| sfn_o | output | 1 | Special fully-nested mode |
| smm_o | output | 1 | Special mask mode |
| ocw2_stb_o | output | 1 | Second-type operation command strobe |
| ocw2_rot_o | output | 1 | Rotate field |
| ocw2_sl_o | output | 1 | Specific field |
| ocw2_eoi_o | output | 1 | End-of-interrupt field |
| ocw2_lvl_o | output | 3 | Level field |

## Verification
The bench aborts initialization in two ways, single mode and a missing fourth word. A design that advanced anyway would load the vector base from what should be a mask write. It also rejects a fourth word without bit 0 and then retries it. A design that dropped back to idle would treat the retry as a mask write and never become ready. It sends operation commands before initialization completes, where a decoder that ignored `ready_o` would emit a strobe or change the readback selection. It reads in poll mode both with and without a winner, and reads again afterwards. A design that did not clear poll on the read would keep acknowledging the winner and never return the request register.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_W2, SEQ_W3, SEQ_W4} seq_e;

  // first init word
  localparam int unsigned I1_IC4  = 0;
  localparam int unsigned I1_SNGL = 1;
  localparam int unsigned I1_INIT = 4;
  // fourth init word
  localparam int unsigned I4_UPM  = 0;
  localparam int unsigned I4_AEOI = 1;
  localparam int unsigned I4_SFNM = 4;
  // operation word selector
  localparam int unsigned OC_SEL3 = 3;
  // third operation word
  localparam int unsigned O3_RIS  = 0;
  localparam int unsigned O3_RR   = 1;
  localparam int unsigned O3_POLL = 2;
  localparam int unsigned O3_SMM  = 5;
  localparam int unsigned O3_ESMM = 6;
  // second operation word
  localparam int unsigned O2_EOI  = 5;
  localparam int unsigned O2_SL   = 6;
  localparam int unsigned O2_ROT  = 7;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_prog_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  parameter bit          IS_MASTER = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                icw1_wr_i,
  input  logic                a1_wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic                ready_o,
  output logic                in_seq_o,
  output logic [NUM_PINS-1:0] vec_base_o,
  output logic                aeoi_o,
  output logic                sfn_o
);
  localparam int unsigned PIN_W = $clog2(NUM_PINS);
  localparam logic [NUM_PINS-1:0] BASE_MASK = {{(NUM_PINS-PIN_W){1'b1}}, {PIN_W{1'b0}}};

  seq_e seq_q;
  logic sfn_req;

  generate
    if (IS_MASTER) begin : g_master
      assign sfn_req = wdata_i[I4_SFNM];
    end else begin : g_slave
      assign sfn_req = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_IDLE;
      ready_o    <= 1'b0;
      vec_base_o <= '0;
      aeoi_o     <= 1'b0;
      sfn_o      <= 1'b0;
    end else if (icw1_wr_i) begin
      ready_o <= 1'b0;
      seq_q   <= (wdata_i[I1_SNGL] || !wdata_i[I1_IC4]) ? SEQ_IDLE : SEQ_W2;
    end else if (a1_wr_i) begin
      case (seq_q)
        SEQ_W2: begin
          vec_base_o <= wdata_i & BASE_MASK;
          seq_q      <= SEQ_W3;
        end
        SEQ_W3: seq_q <= SEQ_W4;
        SEQ_W4: begin
          // unsupported processor mode: stay here and await a retry
          if (wdata_i[I4_UPM]) begin
            aeoi_o  <= wdata_i[I4_AEOI];
            sfn_o   <= sfn_req;
            ready_o <= 1'b1;
            seq_q   <= SEQ_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_seq_o = (seq_q != SEQ_IDLE);
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_prog_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       icw1_wr_i,
  input  logic                       ocw_wr_i,
  input  logic                       mask_wr_i,
  input  logic                       rd_i,
  input  logic [NUM_PINS-1:0]        wdata_i,
  output logic [NUM_PINS-1:0]        mask_o,
  output logic                       smm_o,
  output logic                       rd_isr_o,
  output logic                       poll_o,
  output logic                       ocw2_stb_o,
  output logic                       ocw2_rot_o,
  output logic                       ocw2_sl_o,
  output logic                       ocw2_eoi_o,
  output logic [$clog2(NUM_PINS)-1:0] ocw2_lvl_o
);
  localparam int unsigned PIN_W = $clog2(NUM_PINS);

  logic ocw3_wr;
  assign ocw3_wr    = ocw_wr_i &  wdata_i[OC_SEL3];
  assign ocw2_stb_o = ocw_wr_i & ~wdata_i[OC_SEL3];
  assign ocw2_rot_o = wdata_i[O2_ROT];
  assign ocw2_sl_o  = wdata_i[O2_SL];
  assign ocw2_eoi_o = wdata_i[O2_EOI];
  assign ocw2_lvl_o = wdata_i[PIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
    end else if (icw1_wr_i) begin
      mask_o <= '0;
    end else if (mask_wr_i) begin
      mask_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smm_o    <= 1'b0;
      rd_isr_o <= 1'b0;
      poll_o   <= 1'b0;
    end else if (icw1_wr_i) begin
      smm_o    <= 1'b0;
      rd_isr_o <= 1'b0;
      poll_o   <= 1'b0;
    end else begin
      if (rd_i && poll_o) poll_o <= 1'b0;
      if (ocw3_wr) begin
        if (wdata_i[O3_ESMM]) smm_o <= wdata_i[O3_SMM];
        if (wdata_i[O3_RR]) begin
          rd_isr_o <= wdata_i[O3_RIS];
          poll_o   <= wdata_i[O3_POLL];
        end
      end
    end
  end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                        addr_i,
  input  logic                        rd_i,
  input  logic                        poll_i,
  input  logic                        rd_isr_i,
  input  logic [NUM_PINS-1:0]         mask_i,
  input  logic [NUM_PINS-1:0]         irr_i,
  input  logic [NUM_PINS-1:0]         isr_i,
  input  logic                        win_valid_i,
  input  logic [$clog2(NUM_PINS)-1:0] win_pin_i,
  output logic [NUM_PINS-1:0]         rdata_o,
  output logic                        ack_o
);
  localparam int unsigned PIN_W = $clog2(NUM_PINS);

  always_comb begin
    if (poll_i) begin
      rdata_o = win_valid_i ? {1'b1, {(NUM_PINS-1-PIN_W){1'b0}}, win_pin_i} : '0;
    end else if (addr_i) begin
      rdata_o = mask_i;
    end else begin
      rdata_o = rd_isr_i ? isr_i : irr_i;
    end
  end

  assign ack_o = rd_i & poll_i & win_valid_i;
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
  import pic_prog_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] irr_i,
  input  logic [7:0] isr_i,
  input  logic       win_valid_i,
  input  logic [2:0] win_pin_i,
  output logic       ack_o,
  output logic [2:0] ack_pin_o,
  output logic       ready_o,
  output logic       init_o,
  output logic [7:0] mask_o,
  output logic [7:0] vec_base_o,
  output logic       aeoi_o,
  output logic       sfn_o,
  output logic       smm_o,
  output logic       ocw2_stb_o,
  output logic       ocw2_rot_o,
  output logic       ocw2_sl_o,
  output logic       ocw2_eoi_o,
  output logic [2:0] ocw2_lvl_o
);
  localparam int unsigned NUM_PINS = 8;

  logic a1_wr, icw1_wr, ocw_wr, in_seq, rd_isr, poll;

  assign a1_wr   = wr_i &  addr_i;
  assign icw1_wr = wr_i & ~addr_i &  wdata_i[I1_INIT];
  assign ocw_wr  = wr_i & ~addr_i & ~wdata_i[I1_INIT] & ready_o;
  assign init_o  = icw1_wr;

  pic_init_seq #(.NUM_PINS(NUM_PINS), .IS_MASTER(IS_MASTER)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .icw1_wr_i  (icw1_wr),
    .a1_wr_i    (a1_wr),
    .wdata_i    (wdata_i),
    .ready_o    (ready_o),
    .in_seq_o   (in_seq),
    .vec_base_o (vec_base_o),
    .aeoi_o     (aeoi_o),
    .sfn_o      (sfn_o)
  );

  pic_ocw_dec #(.NUM_PINS(NUM_PINS)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .icw1_wr_i  (icw1_wr),
    .ocw_wr_i   (ocw_wr),
    .mask_wr_i  (a1_wr & ~in_seq),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .mask_o     (mask_o),
    .smm_o      (smm_o),
    .rd_isr_o   (rd_isr),
    .poll_o     (poll),
    .ocw2_stb_o (ocw2_stb_o),
    .ocw2_rot_o (ocw2_rot_o),
    .ocw2_sl_o  (ocw2_sl_o),
    .ocw2_eoi_o (ocw2_eoi_o),
    .ocw2_lvl_o (ocw2_lvl_o)
  );

  pic_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .poll_i      (poll),
    .rd_isr_i    (rd_isr),
    .mask_i      (mask_o),
    .irr_i       (irr_i),
    .isr_i       (isr_i),
    .win_valid_i (win_valid_i),
    .win_pin_i   (win_pin_i),
    .rdata_o     (rdata_o),
    .ack_o       (ack_o)
  );

  assign ack_pin_o = win_pin_i;
endmodule

// File: rtl/pic_prog_if_chk.sv
module pic_prog_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       win_valid_i,
  input logic [2:0] win_pin_i,
  input logic       ack_o,
  input logic       ready_o,
  input logic       init_o,
  input logic [7:0] mask_o,
  input logic [7:0] vec_base_o,
  input logic       sfn_o,
  input logic       smm_o,
  input logic       ocw2_stb_o
);
  // R2
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(wr_i && !addr_i && wdata_i[4]));
  // R2
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> (!ready_o && mask_o == 8'h00 && !smm_o));
  // R4
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vec_base_o) |-> $past(wr_i && addr_i && !ready_o));
  // R5
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(wr_i && addr_i && wdata_i[0]));
  // R5
  sfn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sfn_o) |-> $past(wr_i && addr_i && wdata_i[4]));
  // R6
  mask_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_o) |-> $past(wr_i));
  // R7
  ocw2_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocw2_stb_o |-> ready_o);
  // R10
  poll_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (rd_i && win_valid_i && rdata_o == {5'b10000, win_pin_i}));
endmodule

bind pic_prog_if pic_prog_if_chk u_chk (.*);

// File: tb/test_pic_prog_if.sv
`timescale 1ns/1ps
module test_pic_prog_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, irr = 8'h5A, isr = 8'hC3;
  logic win_v = 1'b1;
  logic [2:0] win_pin = 3'd5;
  logic [7:0] rdata, mask, base;
  logic ack, ready, init, aeoi, sfn, smm, stb, rot, sl, eoi;
  logic [2:0] ack_pin, lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_prog_if #(.IS_MASTER(1'b1)) i_pic_prog_if (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .win_valid_i(win_v), .win_pin_i(win_pin), .ack_o(ack), .ack_pin_o(ack_pin),
    .ready_o(ready), .init_o(init), .mask_o(mask), .vec_base_o(base),
    .aeoi_o(aeoi), .sfn_o(sfn), .smm_o(smm), .ocw2_stb_o(stb),
    .ocw2_rot_o(rot), .ocw2_sl_o(sl), .ocw2_eoi_o(eoi), .ocw2_lvl_o(lvl)
  );

  typedef struct packed {
    logic       is_rd;
    logic       a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h11, 8'h00, 4'd2},
    '{1'b0, 1'b1, 8'h4D, 8'h00, 4'd4},
    '{1'b0, 1'b1, 8'h04, 8'h00, 4'd4},
    '{1'b0, 1'b1, 8'h01, 8'h00, 4'd5},
    '{1'b0, 1'b1, 8'hA5, 8'h00, 4'd6},
    '{1'b1, 1'b1, 8'h00, 8'hA5, 4'd6},
    '{1'b1, 1'b0, 8'h00, 8'h5A, 4'd9},
    '{1'b0, 1'b0, 8'h0B, 8'h00, 4'd9},
    '{1'b1, 1'b0, 8'h00, 8'hC3, 4'd9},
    '{1'b0, 1'b0, 8'h0A, 8'h00, 4'd9},
    '{1'b1, 1'b0, 8'h00, 8'h5A, 4'd9},
    '{1'b0, 1'b0, 8'h0E, 8'h00, 4'd10},
    '{1'b1, 1'b0, 8'h00, 8'h85, 4'd10},
    '{1'b1, 1'b0, 8'h00, 8'h5A, 4'd10},
    '{1'b0, 1'b0, 8'h0F, 8'h00, 4'd10},
    '{1'b1, 1'b0, 8'h00, 8'h85, 4'd10},
    '{1'b1, 1'b0, 8'h00, 8'hC3, 4'd9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  // rdata/ack are sampled mid-cycle while rd is high; the poll clear commits at the edge
  task automatic do_rd(input logic a, output logic [7:0] d, output logic k, output logic [2:0] kp);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    d = rdata; k = ack; kp = ack_pin;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic init_seq(input logic [7:0] w4);
    do_wr(1'b0, 8'h11);
    do_wr(1'b1, 8'h48);
    do_wr(1'b1, 8'h00);
    do_wr(1'b1, w4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic k;
    logic [2:0] kp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready == 0 && mask == 0 && base == 0, "R1", {ready, mask, base}, 0);
    chk(aeoi == 0 && sfn == 0 && smm == 0, "R1", {aeoi, sfn, smm}, 0);
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h5A, "R1", d, 8'h5A);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        do_rd(VECS[i].a, d, k, kp);
        chk(d == VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i), d, VECS[i].exp);
      end else begin
        do_wr(VECS[i].a, VECS[i].d);
      end
    end
    chk(base == 8'h48, "R4", base, 8'h48);
    chk(ready == 1 && aeoi == 0 && sfn == 0, "R5", {ready, aeoi, sfn}, 3'b100);

    // R10 poll ack pulse and pin, then no winner
    do_wr(1'b0, 8'h0E);
    win_pin = 3'd3;
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h83 && k == 1 && kp == 3'd3, "R10", {d, k, kp}, {8'h83, 1'b1, 3'd3});
    do_wr(1'b0, 8'h0E);
    win_v = 1'b0;
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h00 && k == 0, "R10", {d, k}, 0);
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h5A, "R10", d, 8'h5A);
    win_v = 1'b1;

    // R8 special mask enable gating
    do_wr(1'b0, 8'h68);
    chk(smm == 1, "R8", smm, 1);
    do_wr(1'b0, 8'h48);
    chk(smm == 0, "R8", smm, 0);
    do_wr(1'b0, 8'h28);
    chk(smm == 0, "R8", smm, 0);

    // R9 bit 1 clear leaves selection alone
    do_wr(1'b0, 8'h09);
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h5A, "R9", d, 8'h5A);

    // R7 second operation word fields
    @(negedge clk);
    addr = 1'b0; wdata = 8'hE3; wr = 1'b1;
    #1;
    chk(stb && rot && sl && eoi && lvl == 3'd3, "R7", {stb, rot, sl, eoi, lvl}, 7'b1111011);
    @(negedge clk);
    wr = 1'b0;

    // R2 re-init clears state
    do_wr(1'b1, 8'hFF);
    do_wr(1'b0, 8'h68);
    do_wr(1'b0, 8'h0B);
    @(negedge clk);
    addr = 1'b0; wdata = 8'h11; wr = 1'b1;
    #1;
    chk(init == 1, "R2", init, 1);
    @(negedge clk);
    wr = 1'b0;
    chk(ready == 0 && mask == 0 && smm == 0, "R2", {ready, mask, smm}, 0);
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h5A, "R2", d, 8'h5A);

    // R4 third word ignored
    do_wr(1'b1, 8'h21);
    do_wr(1'b1, 8'hFF);
    chk(base == 8'h20 && mask == 0, "R4", {base, mask}, {8'h20, 8'h00});

    // R5 fourth word without bit 0 is retried
    do_wr(1'b1, 8'h02);
    chk(ready == 0 && mask == 0, "R5", {ready, mask}, 0);
    do_wr(1'b1, 8'h13);
    chk(ready == 1 && aeoi == 1 && sfn == 1, "R5", {ready, aeoi, sfn}, 3'b111);

    // R3 abort by single mode
    do_wr(1'b0, 8'h13);
    do_wr(1'b1, 8'h77);
    chk(ready == 0 && mask == 8'h77 && base == 8'h20, "R3", {ready, mask, base}, {1'b0, 8'h77, 8'h20});
    // R7 ignored while not ready
    @(negedge clk);
    addr = 1'b0; wdata = 8'h0B; wr = 1'b1;
    #1;
    chk(stb == 0, "R7", stb, 0);
    @(negedge clk);
    wr = 1'b0;
    do_rd(1'b0, d, k, kp);
    chk(d == 8'h5A, "R7", d, 8'h5A);

    // R3 abort by missing fourth word
    do_wr(1'b0, 8'h10);
    do_wr(1'b1, 8'h3C);
    chk(ready == 0 && mask == 8'h3C && base == 8'h20, "R3", {ready, mask, base}, {1'b0, 8'h3C, 8'h20});

    // R6 mask readback
    do_rd(1'b1, d, k, kp);
    chk(d == 8'h3C, "R6", d, 8'h3C);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule